// File: doc/BRIEF.md
# Break-Detecting Serial Receiver

This block receives asynchronous serial characters on a single input line. It oversamples the line at sixteen samples per bit and decides each bit by a majority vote of the samples in slots 7, 8 and 9. A divider parameter (`CLK_DIV`) sets the oversampling rate, so one bit lasts `16*CLK_DIV` clock cycles. Characters carry one low start bit, eight or nine data bits sent least significant bit first, and one stop bit. The `nine_mode` input selects eight or nine data bits. The received byte is held in a data register. The received ninth bit, the receive-full indication and the framing-error indication are driven on their own output ports.

A status register reports two conditions. The first is that a break character was received, meaning a whole frame of zeros including the stop-bit position. The second is that a reception is in progress. Software reaches both registers through a one-cycle read strobe (`rd_en`) and a register select (`rd_sel`). A read has side effects only while `rd_en` is high. A detected break can be cleared only by a status read while the break flag is set, followed by a data read. After any character, the receiver waits for a high sample on the line before it searches for a new start bit. A line held low therefore produces a single break, and the break flag can only set again after the line has returned high.

The frame engine has five states. Hunt searches for a low sample. Start counts the start bit and can abort it through the false-start transition. Data collects the data bits. Stop samples the stop bit and completes the frame. Wait-high blocks the receiver until the line is high, and the re-arm transition then returns it to Hunt. The break-clear sequencer has two states, Idle and Armed. A status read while the break flag is set moves it from Idle to Armed. A data read moves it from Armed back to Idle, and that move clears the break flag.

Top module: `rxb_break_rx`

## Requirements
- R1: After reset, a status read returns 0x00, and `rx_full`, `frame_err` and `ninth_bit` are all 0.
- R2: A frame is received least significant bit first, each bit decided by a majority of the samples in oversampling slots 7, 8 and 9. At the end of the frame `rx_full` goes to 1, the byte appears on `rd_data` when `rd_sel`=1, and `frame_err` equals the inverse of the sampled stop bit.
- R3: With `nine_mode`=1 the frame carries nine data bits, and the ninth bit received appears on `ninth_bit`. A frame whose eight data bits are zero but whose ninth bit is 1 is not a break.
- R4: A frame that is zero in every data bit and in the stop bit sets the break flag (status bit 1), sets `frame_err` and `rx_full`, and loads 0x00 into the data register.
- R5: In nine-bit mode, a detected break drives `ninth_bit` to 0.
- R6: The break flag clears only when a status read (`rd_sel`=0) made while the flag is set is followed by a data read (`rd_sel`=1). A data read on its own leaves the flag set, and so do repeated status reads on their own.
- R7: After a frame completes, no further frame and no further break is taken until the line has been sampled high. A line held low after a break gives no second break, and a new low frame after a high period does set the flag again.
- R8: The in-progress flag (status bit 0) sets when a low sample is seen in the first oversampling slot of the start-bit search. Status bits 7 to 2 always read 0.
- R9: When the majority of slots 7, 8 and 9 of the start bit is high, the start is false. The in-progress flag then clears, no data is loaded, and the receiver returns to the search.
- R10: The in-progress flag stays set after a completed frame until the line has been high for a full frame time of consecutive samples, which is (data bits + 2) x 16 oversampling ticks. The flag then clears.
- R11: A data read clears `rx_full` and `frame_err`.
- R12: The oversampling tick arrives once every `CLK_DIV` clock cycles, never on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nine_mode | input | 1 | 1 selects nine data bits, 0 selects eight |
| rxd | input | 1 | Serial receive line, idle high |
| rd_en | input | 1 | Read strobe; the read's side effects take place on this cycle |
| rd_sel | input | 1 | Register select: 0 selects status, 1 selects data |
| rd_data | output | DATA_W | Selected register contents; status is {zeros, break, in-progress} |
| rx_full | output | 1 | A received character is waiting |
| frame_err | output | 1 | The last frame had a low stop bit |
| ninth_bit | output | 1 | Ninth data bit of the last frame (nine-bit mode) |

## Verification
The bench builds the block with `CLK_DIV`=2 and the default eight-bit data width. This makes a bit 32 clock cycles long. A full idle frame then fits in a few hundred cycles, which lets one short run cover the false-start abort, the idle timeout, held-low breaks with re-arming, and nine-bit breaks. Odd and even byte patterns, an all-zero byte with a good stop bit, and a nine-bit frame with zero data but a set ninth bit separate the break decision from ordinary zero data.

// File: rtl/rxb_pkg.sv
`timescale 1ns/1ps
package rxb_pkg;
    typedef enum logic [2:0] {
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAIT_HI
    } rx_state_e;

    typedef enum logic {
        CLR_IDLE,
        CLR_ARMED
    } clr_state_e;

    localparam logic SEL_STATUS = 1'b0;
    localparam logic SEL_DATA   = 1'b1;
endpackage

// File: rtl/rxb_tick_gen.sv
`timescale 1ns/1ps
module rxb_tick_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CLK_DIV <= 1) begin : g_every
            always_comb tick = rst_n;
        end else begin : g_count
            localparam int CW = $clog2(CLK_DIV);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                    tick  <= 1'b0;
                end else if (cnt_q == CW'(CLK_DIV - 1)) begin
                    cnt_q <= '0;
                    tick  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                    tick  <= 1'b0;
                end
            end

            // R12: ticks are separated by idle cycles when dividing
            p_tick_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("tick on consecutive cycles");
        end
    endgenerate
endmodule

// File: rtl/rxb_line_sampler.sv
`timescale 1ns/1ps
module rxb_line_sampler #(
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic [IDLE_W-1:0] idle_ticks,
    output logic              rxd_s,
    output logic              idle_evt
);
    logic [1:0]        sync_q;
    logic [IDLE_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], rxd};
        end
    end

    assign rxd_s = sync_q[1];

    // Consecutive high oversampling ticks, saturating at the idle length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (tick) begin
            if (!rxd_s) begin
                run_q <= '0;
            end else if (run_q != idle_ticks) begin
                run_q <= run_q + IDLE_W'(1);
            end
        end
    end

    always_comb begin
        idle_evt = tick && rxd_s && (run_q == idle_ticks - IDLE_W'(1));
    end

    // R10: the idle event fires once per high run
    p_idle_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle_evt |=> !idle_evt)
        else $error("idle event repeated");
endmodule

// File: rtl/rxb_frame_fsm.sv
`timescale 1ns/1ps
module rxb_frame_fsm
    import rxb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd_s,
    input  logic              nine_mode,
    output logic              start_evt,
    output logic              false_evt,
    output logic              frm_valid,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_ninth,
    output logic              frm_stop
);
    localparam int SLOT_W = $clog2(OSR + 1);
    localparam int BIT_W  = $clog2(DATA_W + 1);
    localparam int MID    = OSR / 2;

    rx_state_e         state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d, cur;
    logic [BIT_W-1:0]  bit_q, bit_d, last_bit;
    logic [1:0]        vote_q, vote_d;
    logic [DATA_W:0]   shr_q, shr_d;
    logic              maj;

    always_comb begin
        cur      = slot_q + SLOT_W'(1);
        maj      = (vote_q[0] & vote_q[1]) | (rxd_s & (vote_q[0] | vote_q[1]));
        last_bit = nine_mode ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        bit_d   = bit_q;
        vote_d  = vote_q;
        shr_d   = shr_q;
        if (tick) begin
            if (state_q == RX_START || state_q == RX_DATA || state_q == RX_STOP) begin
                slot_d = cur;
                if (cur == SLOT_W'(MID - 1)) vote_d[0] = rxd_s;
                if (cur == SLOT_W'(MID))     vote_d[1] = rxd_s;
            end
            unique case (state_q)
                RX_HUNT: begin
                    if (!rxd_s) begin
                        state_d = RX_START;
                        slot_d  = SLOT_W'(1);
                    end
                end
                RX_START: begin
                    if (cur == SLOT_W'(MID + 1) && maj) begin
                        state_d = RX_HUNT;
                    end else if (cur == SLOT_W'(OSR)) begin
                        state_d = RX_DATA;
                        slot_d  = '0;
                        bit_d   = '0;
                    end
                end
                RX_DATA: begin
                    if (cur == SLOT_W'(MID + 1)) begin
                        shr_d = {maj, shr_q[DATA_W:1]};
                    end
                    if (cur == SLOT_W'(OSR)) begin
                        slot_d = '0;
                        if (bit_q == last_bit) begin
                            state_d = RX_STOP;
                        end else begin
                            bit_d = bit_q + BIT_W'(1);
                        end
                    end
                end
                RX_STOP: begin
                    if (cur == SLOT_W'(MID + 1)) begin
                        state_d = RX_WAIT_HI;
                    end
                end
                RX_WAIT_HI: begin
                    if (rxd_s) begin
                        state_d = RX_HUNT;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_HUNT;
            slot_q  <= '0;
            bit_q   <= '0;
            vote_q  <= 2'b11;
            shr_q   <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            bit_q   <= bit_d;
            vote_q  <= vote_d;
            shr_q   <= shr_d;
        end
    end

    // Outputs
    always_comb begin
        start_evt = tick && (state_q == RX_HUNT) && !rxd_s;
        false_evt = tick && (state_q == RX_START) && (cur == SLOT_W'(MID + 1)) && maj;
        frm_valid = tick && (state_q == RX_STOP) && (cur == SLOT_W'(MID + 1));
        frm_stop  = maj;
        frm_data  = nine_mode ? shr_q[DATA_W-1:0] : shr_q[DATA_W:1];
        frm_ninth = nine_mode ? shr_q[DATA_W] : 1'b0;
    end

    // R7: a low line keeps the engine blocked after a frame
    p_rearm_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_WAIT_HI && tick && !rxd_s) |=> state_q == RX_WAIT_HI)
        else $error("left wait-high on a low sample");

    // R8: the first low sample counts as slot one of the start bit
    p_start_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state_q == RX_START && slot_q == SLOT_W'(1)))
        else $error("start search did not begin at slot one");

    // R9: a false start returns to the search
    p_false_hunt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        false_evt |=> state_q == RX_HUNT)
        else $error("false start did not return to hunt");
endmodule

// File: rtl/rxb_status_regs.sv
`timescale 1ns/1ps
module rxb_status_regs
    import rxb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nine_mode,
    input  logic              start_evt,
    input  logic              false_evt,
    input  logic              idle_evt,
    input  logic              frm_valid,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_ninth,
    input  logic              frm_stop,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_full,
    output logic              frame_err,
    output logic              ninth_bit
);
    clr_state_e        clr_q, clr_d;
    logic [DATA_W-1:0] data_q;
    logic              brk_q, rip_q, rxf_q, fe_q, n9_q;
    logic              brk_hit, rd_stat, rd_dat, brk_clear;

    always_comb begin
        rd_stat = rd_en && (rd_sel == SEL_STATUS);
        rd_dat  = rd_en && (rd_sel == SEL_DATA);
        brk_hit = frm_valid && (frm_data == '0) && !frm_stop
                  && (!nine_mode || !frm_ninth);
    end

    // Break-clear sequencer
    always_comb begin
        clr_d     = clr_q;
        brk_clear = 1'b0;
        unique case (clr_q)
            CLR_IDLE: begin
                if (rd_stat && brk_q) clr_d = CLR_ARMED;
            end
            CLR_ARMED: begin
                if (rd_dat) begin
                    clr_d     = CLR_IDLE;
                    brk_clear = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_q  <= CLR_IDLE;
            data_q <= '0;
            brk_q  <= 1'b0;
            rip_q  <= 1'b0;
            rxf_q  <= 1'b0;
            fe_q   <= 1'b0;
            n9_q   <= 1'b0;
        end else begin
            clr_q <= clr_d;
            if (brk_hit)        brk_q <= 1'b1;
            else if (brk_clear) brk_q <= 1'b0;
            if (start_evt)                  rip_q <= 1'b1;
            else if (false_evt || idle_evt) rip_q <= 1'b0;
            if (frm_valid) begin
                data_q <= frm_data;
                rxf_q  <= 1'b1;
                fe_q   <= !frm_stop;
                n9_q   <= brk_hit ? 1'b0 : frm_ninth;
            end else if (rd_dat) begin
                rxf_q <= 1'b0;
                fe_q  <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data   = (rd_sel == SEL_DATA) ? data_q : {{(DATA_W-2){1'b0}}, brk_q, rip_q};
        rx_full   = rxf_q;
        frame_err = fe_q;
        ninth_bit = n9_q;
    end

    // R4: a new break comes with framing error and receive-full
    p_brk_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_q) |-> (fe_q && rxf_q))
        else $error("break without companion flags");

    // R5: nine-bit break leaves the ninth bit low
    p_brk_ninth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(brk_q) && nine_mode) |-> !ninth_bit)
        else $error("ninth bit set on break");

    // R6: the break flag only falls on a data read that follows the armed status read
    p_brk_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_q) |-> $past(clr_q == CLR_ARMED && rd_dat))
        else $error("break cleared outside the read sequence");

    p_brk_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_q && !rd_dat) |=> brk_q)
        else $error("break lost without a data read");

    // R8: in-progress follows a start sample
    p_rip_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> rip_q)
        else $error("in-progress not set");

    // R9 / R10: false start and idle drop in-progress
    p_rip_false_r9: assert property (@(posedge clk) disable iff (!rst_n)
        false_evt |=> !rip_q)
        else $error("in-progress kept after false start");

    p_rip_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle_evt |=> !rip_q)
        else $error("in-progress kept after idle");

    // R11: data read drops receive-full and framing error
    p_rd_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dat && !frm_valid) |=> (!rx_full && !frame_err))
        else $error("data read did not clear flags");
endmodule

// File: rtl/rxb_break_rx.sv
`timescale 1ns/1ps
module rxb_break_rx #(
    parameter int CLK_DIV = 4,
    parameter int DATA_W  = 8,
    parameter int OSR     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nine_mode,
    input  logic              rxd,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_full,
    output logic              frame_err,
    output logic              ninth_bit
);
    localparam int IDLE_SHORT = (DATA_W + 2) * OSR;
    localparam int IDLE_LONG  = (DATA_W + 3) * OSR;
    localparam int IDLE_W     = $clog2(IDLE_LONG + 1);

    logic              tick, rxd_s, idle_evt;
    logic              start_evt, false_evt, frm_valid, frm_ninth, frm_stop;
    logic [DATA_W-1:0] frm_data;
    logic [IDLE_W-1:0] idle_ticks;

    always_comb begin
        idle_ticks = nine_mode ? IDLE_W'(IDLE_LONG) : IDLE_W'(IDLE_SHORT);
    end

    rxb_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    rxb_line_sampler #(.IDLE_W(IDLE_W)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rxd       (rxd),
        .idle_ticks(idle_ticks),
        .rxd_s     (rxd_s),
        .idle_evt  (idle_evt)
    );

    rxb_frame_fsm #(.DATA_W(DATA_W), .OSR(OSR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rxd_s    (rxd_s),
        .nine_mode(nine_mode),
        .start_evt(start_evt),
        .false_evt(false_evt),
        .frm_valid(frm_valid),
        .frm_data (frm_data),
        .frm_ninth(frm_ninth),
        .frm_stop (frm_stop)
    );

    rxb_status_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .nine_mode(nine_mode),
        .start_evt(start_evt),
        .false_evt(false_evt),
        .idle_evt (idle_evt),
        .frm_valid(frm_valid),
        .frm_data (frm_data),
        .frm_ninth(frm_ninth),
        .frm_stop (frm_stop),
        .rd_en    (rd_en),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .rx_full  (rx_full),
        .frame_err(frame_err),
        .ninth_bit(ninth_bit)
    );
endmodule

// File: tb/test_rxb_break_rx.sv
`timescale 1ns/1ps
module test_rxb_break_rx;
    localparam int DIV = 2;
    localparam int BIT = 16 * DIV;

    typedef struct {
        logic [7:0] data;
        logic       ninth;
        logic       fe;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nine_mode = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       rx_full, frame_err, ninth_bit;

    int   n_checks = 0;
    int   n_errors = 0;
    int   cyc = 0;
    exp_t sb_q[$];

    rxb_break_rx #(.CLK_DIV(DIV), .DATA_W(8), .OSR(16)) i_rxb_break_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .nine_mode(nine_mode),
        .rxd      (rxd),
        .rd_en    (rd_en),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .rx_full  (rx_full),
        .frame_err(frame_err),
        .ninth_bit(ninth_bit)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_errors = n_errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_errors = n_errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic view(input logic sel, output logic [7:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic do_read(input logic sel);
        @(negedge clk);
        rd_sel = sel;
        rd_en  = 1'b1;
        @(negedge clk);
        rd_en  = 1'b0;
    endtask

    task automatic hold(input logic v, input int bits);
        rxd = v;
        repeat (bits * BIT) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] d, input int nd, input logic stop_v, input int tail);
        @(negedge clk);
        hold(1'b0, 1);
        for (int i = 0; i < nd; i++) hold(d[i], 1);
        hold(stop_v, 1);
        if (tail > 0) hold(1'b1, tail);
    endtask

    task automatic push(input logic [7:0] d, input logic n9, input logic fe);
        exp_t e;
        e.data  = d;
        e.ninth = n9;
        e.fe    = fe;
        sb_q.push_back(e);
    endtask

    task automatic drain();
        for (int i = 0; i < 4000 && sb_q.size() > 0; i++) @(negedge clk);
        chk("R2 scoreboard drained", 16'(sb_q.size()), 16'd0);
    endtask

    // Monitor: compares each completed frame, then clears it with status+data reads
    initial begin
        logic [7:0] v;
        exp_t e;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0 && rx_full) begin
                e = sb_q.pop_front();
                view(1'b1, v);
                chk("R2 data", 16'(v), 16'(e.data));
                chk("R2 frame_err", 16'(frame_err), 16'(e.fe));
                chk("R3 ninth_bit", 16'(ninth_bit), 16'(e.ninth));
                view(1'b0, v);
                chk("R4 no break on ordinary frame", 16'(v[1]), 16'd0);
                do_read(1'b0);
                do_read(1'b1);
                #1;
                chk("R11 rx_full cleared", 16'(rx_full), 16'd0);
                chk("R11 frame_err cleared", 16'(frame_err), 16'd0);
            end
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        view(1'b0, v);
        chk("R1 status after reset", 16'(v), 16'h00);
        chk("R1 rx_full", 16'(rx_full), 16'd0);
        chk("R1 frame_err", 16'(frame_err), 16'd0);
        chk("R1 ninth_bit", 16'(ninth_bit), 16'd0);
        rst_n = 1'b1;
        repeat (12 * BIT) @(negedge clk);

        // R2: eight-bit patterns, including zero data with a good stop
        push(8'hA5, 1'b0, 1'b0); send(9'h0A5, 8, 1'b1, 1); drain();
        push(8'h3C, 1'b0, 1'b0); send(9'h03C, 8, 1'b1, 1); drain();
        push(8'hFF, 1'b0, 1'b0); send(9'h0FF, 8, 1'b1, 1); drain();
        push(8'h00, 1'b0, 1'b0); send(9'h000, 8, 1'b1, 1); drain();
        // R2: low stop bit gives a framing error, not a break
        push(8'h12, 1'b0, 1'b1); send(9'h012, 8, 1'b0, 1); drain();

        // R10: in-progress survives the frame until a full idle frame of ones
        push(8'h55, 1'b0, 1'b0); send(9'h055, 8, 1'b1, 1); drain();
        view(1'b0, v);
        chk("R10 in-progress before idle", 16'(v[0]), 16'd1);
        repeat (10 * BIT) @(negedge clk);
        view(1'b0, v);
        chk("R10 in-progress after idle", 16'(v[0]), 16'd0);

        // R8 / R9: short low pulse is a false start
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (2) @(negedge clk);
        view(1'b0, v);
        chk("R8 in-progress on start sample", 16'(v), 16'h01);
        repeat (40) @(negedge clk);
        view(1'b0, v);
        chk("R9 in-progress cleared by false start", 16'(v[0]), 16'd0);
        chk("R9 no data from false start", 16'(rx_full), 16'd0);

        // R4 / R6 / R7: break with line held low
        send(9'h000, 8, 1'b0, 0);
        view(1'b0, v);
        chk("R4 break flag", 16'(v[1]), 16'd1);
        chk("R8 upper status bits zero", 16'(v[7:2]), 16'd0);
        chk("R4 frame_err on break", 16'(frame_err), 16'd1);
        chk("R4 rx_full on break", 16'(rx_full), 16'd1);
        view(1'b1, v);
        chk("R4 break data", 16'(v), 16'h00);
        do_read(1'b1);
        view(1'b0, v);
        chk("R6 data read alone keeps break", 16'(v[1]), 16'd1);
        chk("R11 data read clears rx_full", 16'(rx_full), 16'd0);
        do_read(1'b0);
        do_read(1'b0);
        view(1'b0, v);
        chk("R6 status reads alone keep break", 16'(v[1]), 16'd1);
        do_read(1'b1);
        view(1'b0, v);
        chk("R6 status then data clears break", 16'(v[1]), 16'd0);
        repeat (3 * BIT) @(negedge clk);
        view(1'b0, v);
        chk("R7 held-low line gives no new break", 16'(v[1]), 16'd0);
        chk("R7 held-low line gives no new frame", 16'(rx_full), 16'd0);
        hold(1'b1, 2);
        send(9'h000, 8, 1'b0, 2);
        view(1'b0, v);
        chk("R7 break after line returned high", 16'(v[1]), 16'd1);
        do_read(1'b0);
        do_read(1'b1);
        view(1'b0, v);
        chk("R6 sequence clears re-armed break", 16'(v[1]), 16'd0);

        // R3 / R5: nine-bit mode
        hold(1'b1, 12);
        nine_mode = 1'b1;
        push(8'h81, 1'b1, 1'b0); send(9'h181, 9, 1'b1, 1); drain();
        push(8'h00, 1'b1, 1'b0); send(9'h100, 9, 1'b1, 1); drain();
        chk("R3 ninth bit held after reads", 16'(ninth_bit), 16'd1);
        send(9'h000, 9, 1'b0, 2);
        view(1'b0, v);
        chk("R4 nine-bit break flag", 16'(v[1]), 16'd1);
        chk("R5 break clears ninth bit", 16'(ninth_bit), 16'd0);
        chk("R4 nine-bit break frame_err", 16'(frame_err), 16'd1);
        do_read(1'b0);
        do_read(1'b1);
        view(1'b0, v);
        chk("R6 nine-bit break cleared", 16'(v[1]), 16'd0);

        repeat (20) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule